// File: doc/BRIEF.md
# Serial Port Interrupt Status Unit

This block gathers the interrupt conditions of a synchronous serial port that has transmit and receive FIFOs, and turns them into one interrupt line. The FIFO occupancy counts and single-cycle event pulses come in as inputs. These are the final bit leaving the serializer, transmit DMA completion, receive DMA completion, a receive timeout and a receive overrun. The FIFOs, the shifter, the DMA engine and the timeout counter sit outside the block.

Two kinds of status bit live side by side. The two FIFO threshold bits follow the fill levels and clear themselves. The five event bits are sticky: an event sets them, and software clears them by writing 1 to the clear register. A small word-addressed register port reads back the raw status, the enable mask and the masked status, and accepts clear writes. The interrupt output is high while any enabled status bit is set.

Top module: `sirq_status_unit`

## Requirements
- R1: Bits 31 down to 7 of every read word are 0. The mask register keeps only bits 6..0 of a write.
- R2: Register addresses are 0 raw status, 1 mask, 2 masked status and 3 clear. Address 3 reads 0. Status bit positions are 6 end-of-transmit, 5 transmit DMA done, 4 receive DMA done, 3 transmit threshold, 2 receive threshold, 1 receive timeout and 0 receive overrun.
- R3: After reset the raw status reads 0x08 and the mask reads 0.
- R4: Writes to address 0 or address 2 change no register.
- R5: From the cycle after a clock edge at which tx_level <= DEPTH/2, bit 3 reads 1. Otherwise it reads 0. Clear writes have no effect on bit 3.
- R6: From the cycle after a clock edge at which rx_level >= DEPTH/2, bit 2 reads 1. Otherwise it reads 0. Clear writes have no effect on bit 2.
- R7: Bit 6 sets after a clock edge at which tx_last_bit is 1 and tx_level is 0. A pulse while tx_level is non-zero does not set it.
- R8: Bits 5, 4, 1 and 0 set after a clock edge with their event input high. Each holds until a write to address 3 with a 1 at its position. A 0 at that position leaves it unchanged.
- R9: When an event and a clear write for the same bit fall on the same edge, the bit ends up set.
- R10: The masked status equals raw AND mask. irq is 1 exactly when the masked status is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_level | input | CNT_W | Transmit FIFO occupancy |
| rx_level | input | CNT_W | Receive FIFO occupancy |
| tx_last_bit | input | 1 | Pulse: final bit has left the shifter |
| tx_dma_done | input | 1 | Pulse: transmit DMA finished |
| rx_dma_done | input | 1 | Pulse: receive DMA finished |
| rx_timeout | input | 1 | Pulse: receive timeout |
| rx_overrun | input | 1 | Pulse: receive overrun |
| reg_addr | input | 2 | Word address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq | output | 1 | Combined interrupt |

## Verification
The fill levels are swept through every value from 0 to DEPTH. This separates the inclusive half-way comparisons from exclusive ones and shows the one-cycle lag of the threshold bits. The end-of-transmit pulse is applied once with the transmit FIFO empty and once with it non-empty, which tells the qualified set apart from a plain latch. The sticky bits are tried with clears of 1, clears of 0 and an event that coincides with a clear, which exposes lost events and bits that clear too eagerly. Mask patterns of single bits and of all bits show whether each position reaches the interrupt line on its own.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int STAT_W = 7;

  localparam int B_OVR  = 0;
  localparam int B_RTO  = 1;
  localparam int B_RXTH = 2;
  localparam int B_TXTH = 3;
  localparam int B_RXDM = 4;
  localparam int B_TXDM = 5;
  localparam int B_EOT  = 6;

  // positions held by write-1-to-clear event flags
  localparam logic [STAT_W-1:0] STICKY_SEL = 7'b111_0011;
  localparam logic [STAT_W-1:0] RESET_RAW  = 7'b000_1000;

  typedef enum logic [1:0] {
    A_RAW    = 2'd0,
    A_MASK   = 2'd1,
    A_MASKED = 2'd2,
    A_CLEAR  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/sirq_level_flags.sv
module sirq_level_flags #(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tx_level,
  input  logic [CNT_W-1:0] rx_level,
  output logic             tx_thr,
  output logic             rx_thr
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(DEPTH / 2);

  logic tx_d, rx_d, tx_q, rx_q;
  logic tx_en, rx_en;

  always_comb begin
    tx_d  = (tx_level <= HALF);
    rx_d  = (rx_level >= HALF);
    tx_en = (tx_d != tx_q);
    rx_en = (rx_d != rx_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= 1'b1;
      rx_q <= 1'b0;
    end else begin
      if (tx_en) tx_q <= tx_d;
      if (rx_en) rx_q <= rx_d;
    end
  end

  assign tx_thr = tx_q;
  assign rx_thr = rx_q;
endmodule

// File: rtl/sirq_event_flags.sv
module sirq_event_flags #(
  parameter int                  N   = 7,
  parameter logic [N-1:0]        SEL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (SEL[i]) begin : g_flop
      logic d, q, en;
      always_comb begin
        en = set_i[i] | clr_i[i];
        d  = set_i[i] | (q & ~clr_i[i]);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= 1'b0;
        else if (en) q <= d;
      end
      assign flag_o[i] = q;
    end else begin : g_none
      logic unused_in;
      assign unused_in = set_i[i] ^ clr_i[i];
      assign flag_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/sirq_regfile.sv
module sirq_regfile
  import sirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  input  logic [STAT_W-1:0] raw_i,
  output logic [STAT_W-1:0] mask_o,
  output logic [STAT_W-1:0] clr_o,
  output logic [31:0]       reg_rdata
);
  logic [STAT_W-1:0] mask_q, mask_d;
  logic              mask_en;
  logic [STAT_W-1:0] masked;
  logic              unused_hi;

  assign unused_hi = ^reg_wdata[31:STAT_W];

  always_comb begin
    mask_en = reg_wr && (reg_sel_e'(reg_addr) == A_MASK);
    mask_d  = reg_wdata[STAT_W-1:0];
    clr_o   = (reg_wr && (reg_sel_e'(reg_addr) == A_CLEAR)) ?
              reg_wdata[STAT_W-1:0] : '0;
    masked  = raw_i & mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel_e'(reg_addr))
      A_RAW:    reg_rdata[STAT_W-1:0] = raw_i;
      A_MASK:   reg_rdata[STAT_W-1:0] = mask_q;
      A_MASKED: reg_rdata[STAT_W-1:0] = masked;
      A_CLEAR:  reg_rdata = '0;
      default:  reg_rdata = '0;
    endcase
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/sirq_status_unit.sv
module sirq_status_unit
  import sirq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tx_level,
  input  logic [CNT_W-1:0] rx_level,
  input  logic             tx_last_bit,
  input  logic             tx_dma_done,
  input  logic             rx_dma_done,
  input  logic             rx_timeout,
  input  logic             rx_overrun,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             irq
);
  logic [STAT_W-1:0] ev_set, ev_clr, ev_flags;
  logic [STAT_W-1:0] raw_word, mask_word;
  logic              tx_thr, rx_thr;

  always_comb begin
    ev_set         = '0;
    ev_set[B_EOT]  = tx_last_bit && (tx_level == '0);
    ev_set[B_TXDM] = tx_dma_done;
    ev_set[B_RXDM] = rx_dma_done;
    ev_set[B_RTO]  = rx_timeout;
    ev_set[B_OVR]  = rx_overrun;
  end

  sirq_level_flags #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_level (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_level(tx_level),
    .rx_level(rx_level),
    .tx_thr  (tx_thr),
    .rx_thr  (rx_thr)
  );

  sirq_event_flags #(.N(STAT_W), .SEL(STICKY_SEL)) u_events (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (ev_set),
    .clr_i (ev_clr),
    .flag_o(ev_flags)
  );

  always_comb begin
    raw_word         = ev_flags;
    raw_word[B_TXTH] = tx_thr;
    raw_word[B_RXTH] = rx_thr;
  end

  sirq_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .raw_i    (raw_word),
    .mask_o   (mask_word),
    .clr_o    (ev_clr),
    .reg_rdata(reg_rdata)
  );

  assign irq = |(raw_word & mask_word);
endmodule

// File: rtl/sirq_status_unit_chk.sv
module sirq_status_unit_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] tx_level,
  input logic [CNT_W-1:0] rx_level,
  input logic             rx_timeout,
  input logic [1:0]       reg_addr,
  input logic             reg_wr,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic             irq,
  input logic [6:0]       raw_word,
  input logic [6:0]       mask_word
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(DEPTH / 2);

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:7] == '0);

  a_r5_tx_thr_track: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> raw_word[3] == ($past(tx_level) <= HALF));

  a_r6_rx_thr_track: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> raw_word[2] == ($past(rx_level) >= HALF));

  a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_word[1] && !(reg_wr && reg_addr == 2'd3 && reg_wdata[1])) |=> raw_word[1]);

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rx_timeout |=> raw_word[1]);

  a_r10_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_word != '0));
endmodule

bind sirq_status_unit sirq_status_unit_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_level  (tx_level),
  .rx_level  (rx_level),
  .rx_timeout(rx_timeout),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq       (irq),
  .raw_word  (raw_word),
  .mask_word (mask_word)
);

// File: tb/test_sirq_status_unit.sv
module test_sirq_status_unit;
  localparam int CLK_P = 10;
  localparam int DEPTH = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int HALF  = DEPTH / 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [CNT_W-1:0] tx_level, rx_level;
  logic             tx_last_bit, tx_dma_done, rx_dma_done, rx_timeout, rx_overrun;
  logic [1:0]       reg_addr;
  logic             reg_wr;
  logic [31:0]      reg_wdata;
  logic [31:0]      reg_rdata;
  logic             irq;

  int    n_cmp = 0, n_bad = 0, cycles = 0;
  string tag = "R3";
  bit    done = 0;
  int    m_raw, m_mask;

  sirq_status_unit #(.DEPTH(DEPTH)) i_sirq_status_unit (
    .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
    .tx_last_bit(tx_last_bit), .tx_dma_done(tx_dma_done), .rx_dma_done(rx_dma_done),
    .rx_timeout(rx_timeout), .rx_overrun(rx_overrun), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference: status as integers, updated per clock edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_raw  = 8;
      m_mask = 0;
    end else begin
      int clr, nxt;
      clr = (reg_wr && reg_addr == 3) ? int'(reg_wdata[6:0]) : 0;
      nxt = m_raw & ~clr & 'h73;
      if (tx_last_bit && tx_level == 0) nxt |= 64;
      if (tx_dma_done) nxt |= 32;
      if (rx_dma_done) nxt |= 16;
      if (rx_timeout)  nxt |= 2;
      if (rx_overrun)  nxt |= 1;
      if (int'(tx_level) <= HALF) nxt |= 8;
      if (int'(rx_level) >= HALF) nxt |= 4;
      if (reg_wr && reg_addr == 1) m_mask = int'(reg_wdata[6:0]);
      m_raw = nxt;
    end
  end

  function automatic int exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return m_raw;
      2'd1:    return m_mask;
      2'd2:    return m_raw & m_mask;
      default: return 0;
    endcase
  endfunction

  task automatic cmp(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s t=%0t got=0x%0h exp=0x%0h", req, $time, got, exp);
    end
  endtask

  // compare on every clock, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (!done) begin
      cmp(tag, int'(reg_rdata), exp_rd(reg_addr));
      cmp("R10 irq", int'(irq), int'((m_raw & m_mask) != 0));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic idle();
    tx_last_bit = 0; tx_dma_done = 0; rx_dma_done = 0;
    rx_timeout = 0; rx_overrun = 0; reg_wr = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    tick();
    reg_wr = 0;
  endtask

  task automatic rd_all();
    for (int a = 0; a < 4; a++) begin reg_addr = 2'(a); tick(); end
    reg_addr = 0;
  endtask

  initial begin
    rst_n = 0; tx_level = 0; rx_level = 0; reg_addr = 0; reg_wdata = 0;
    idle();
    tick(3);
    rst_n = 1;
    tag = "R3 reset";  rd_all();

    tag = "R1 reserved"; wr(1, 32'hFFFF_FFFF); rd_all();
    tag = "R4 ignored";  wr(0, 32'h0000_007F); wr(2, 32'h0000_0000); rd_all();
    tag = "R2 map";      wr(1, 32'h0000_0008); rd_all();

    tag = "R5 tx thr";
    for (int l = 0; l <= DEPTH; l++) begin tx_level = CNT_W'(l); tick(); end
    wr(3, 32'h7F); tick();
    for (int l = DEPTH; l >= 0; l--) begin tx_level = CNT_W'(l); tick(); end
    wr(3, 32'h7F); tick();

    tag = "R6 rx thr"; wr(1, 32'h04);
    for (int l = 0; l <= DEPTH; l++) begin rx_level = CNT_W'(l); tick(); end
    wr(3, 32'h7F); tick();
    for (int l = DEPTH; l >= 0; l--) begin rx_level = CNT_W'(l); tick(); end

    tag = "R7 eot"; wr(1, 32'h40);
    tx_level = 3; tx_last_bit = 1; tick(); tx_last_bit = 0; tick(2);
    tx_level = 0; tx_last_bit = 1; tick(); tx_last_bit = 0; tick(2);
    wr(3, 32'h40); tick(2);

    tag = "R8 sticky"; wr(1, 32'h00);
    tx_dma_done = 1; rx_dma_done = 1; rx_timeout = 1; rx_overrun = 1; tick();
    idle(); tick(3);
    wr(3, 32'h00); tick();
    reg_addr = 2; wr(1, 32'h33); tick();
    wr(3, 32'h01); tick(); wr(3, 32'h02); tick();
    wr(3, 32'h10); tick(); wr(3, 32'h20); tick();
    for (int b = 0; b < 7; b++) begin
      wr(1, 32'(1 << b));
      if (b != 3 && b != 2) begin
        case (b)
          0: rx_overrun = 1; 1: rx_timeout = 1; 4: rx_dma_done = 1;
          5: tx_dma_done = 1; default: tx_last_bit = 1;
        endcase
        tick(); idle(); tick();
        wr(3, 32'(1 << b)); tick();
      end
    end

    tag = "R9 set wins"; wr(1, 32'h7F);
    rx_timeout = 1; rx_overrun = 1; reg_addr = 3; reg_wdata = 32'h7F; reg_wr = 1;
    tick(); idle(); reg_addr = 0; tick(2);
    wr(3, 32'h03); tick(2);

    tag = "R10 masked"; reg_addr = 2;
    tx_dma_done = 1; tick(); idle();
    wr(1, 32'h00); tick(); wr(1, 32'h20); tick(); wr(1, 32'h7F); tick();
    rd_all();

    tick(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule